// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Cell

One processing element of a cascaded FIR filter array. Every clock it multiplies an 8-bit signal sample by an 8-bit coefficient and adds the product into a 26-bit running sum. A synchronous erase input starts a new sum. Each operand has its own flag that selects unsigned or two's-complement arithmetic, so mixed-format products come straight out of the multiplier.

The coefficient is registered and passed on to the next cell. A load enable freezes it, so a coefficient set can be held in place across a chain of cells. The sample is also passed on, through a short delay line of three extra registers. A 2-bit selector sets how many of those registers are in the path. Neighbouring cells then see samples spaced 2, 3 or 4 clocks apart, which is what a polyphase or decimating arrangement needs. Throughput is one multiply-accumulate per clock. A chain of N cells therefore performs N multiply-accumulates per input sample.

Top module: `fir_mac_cell`

## Requirements
- R1: While rst_ni is low, acc_o, sample_o and coef_o are all zero.
- R2: With data_signed_i = 1, sample_i is taken as two's complement (0x80 = -128). With data_signed_i = 0, it is taken as unsigned (0x80 = 128).
- R3: With coef_signed_i = 1, coef_i is taken as two's complement. With coef_signed_i = 0, it is taken as unsigned. This choice is independent of data_signed_i.
- R4: If erase_i is 0 at a clock edge, acc_o after that edge equals acc_o before it plus the sign-extended product of sample_i and coef_i, modulo 2^26.
- R5: If erase_i is 1 at a clock edge, acc_o after that edge equals the product of that edge's operands alone. The old sum is discarded.
- R6: If coef_en_i is 1 at an edge, coef_o takes coef_i. Otherwise coef_o keeps its value.
- R7: With decim_sel_i = 0, sample_o after an edge equals sample_i at that edge (one-register delay).
- R8: With decim_sel_i = k (1, 2 or 3), sample_o after an edge equals sample_i as it was k edges earlier. The total delay is therefore 2, 3 or 4 clocks.
- R9: The accumulator wraps silently past 2^26 - 1. Only the low 26 bits of the true sum are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Signal sample |
| coef_i | input | 8 | Coefficient |
| coef_en_i | input | 1 | Load enable for the forwarded coefficient |
| data_signed_i | input | 1 | 1: sample is two's complement |
| coef_signed_i | input | 1 | 1: coefficient is two's complement |
| decim_sel_i | input | 2 | Number of extra sample delay stages (0 to 3) |
| erase_i | input | 1 | Restart the sum with the current product |
| acc_o | output | 26 | Registered accumulator |
| sample_o | output | 8 | Forwarded, delayed sample |
| coef_o | output | 8 | Forwarded coefficient |

## Verification
The checker tests the coefficient load and hold rule on every cycle. It also tests the sample delay for each selector value, once the delay line holds only post-reset data. A sum must stay unchanged when either operand is zero, and an erase with a zero operand must leave zero. The signed and unsigned interpretation of each operand, the exact accumulated value, and the wrap past 2^26 are shown only by the bench. It uses directed mixed-mode products, a long run of maximum unsigned products, and random traffic, all compared against an independent model.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;
  typedef enum logic [1:0] {
    DECIM_NONE = 2'd0,
    DECIM_BY2  = 2'd1,
    DECIM_BY3  = 2'd2,
    DECIM_BY4  = 2'd3
  } decim_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_COEF_W = 8;
  localparam int unsigned DEF_ACC_W  = 26;
endpackage

// File: rtl/fir_cell_mult.sv
module fir_cell_mult #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned PROD_W = DATA_W + COEF_W + 2
) (
  input  logic [DATA_W-1:0]        data_i,
  input  logic [COEF_W-1:0]        coef_i,
  input  logic                     data_signed_i,
  input  logic                     coef_signed_i,
  output logic signed [PROD_W-1:0] prod_o
);
  // one guard bit makes unsigned and signed operands share a signed multiplier
  logic signed [DATA_W:0] data_x;
  logic signed [COEF_W:0] coef_x;

  assign data_x = {data_signed_i & data_i[DATA_W-1], data_i};
  assign coef_x = {coef_signed_i & coef_i[COEF_W-1], coef_i};
  assign prod_o = data_x * coef_x;
endmodule

// File: rtl/fir_cell_acc.sv
module fir_cell_acc #(
  parameter int unsigned PROD_W = 18,
  parameter int unsigned ACC_W  = 26
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     erase_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]         acc_o
);
  localparam int unsigned EXT_W = ACC_W - PROD_W;

  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] acc_q;

  assign prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};
  assign base     = erase_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= base + prod_ext;  // wraps modulo 2^ACC_W
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fir_cell_decim.sv
module fir_cell_decim #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 3,
  parameter int unsigned SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] tap [STAGES+1];
  logic [WIDTH-1:0] pick;
  logic [WIDTH-1:0] out_q;

  assign tap[0] = data_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= tap[g];
    end
    assign tap[g+1] = stage_q;
  end

  always_comb begin
    pick = tap[STAGES];
    for (int i = 0; i <= STAGES; i++) begin
      if (int'(sel_i) == i) pick = tap[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= pick;
  end

  assign data_o = out_q;
endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int unsigned DATA_W       = fir_cell_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W       = fir_cell_pkg::DEF_COEF_W,
  parameter int unsigned ACC_W        = fir_cell_pkg::DEF_ACC_W,
  parameter int unsigned DECIM_STAGES = 3,
  parameter int unsigned SEL_W        = $clog2(DECIM_STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              coef_en_i,
  input  logic              data_signed_i,
  input  logic              coef_signed_i,
  input  logic [SEL_W-1:0]  decim_sel_i,
  input  logic              erase_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [DATA_W-1:0] sample_o,
  output logic [COEF_W-1:0] coef_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W + 2;

  logic signed [PROD_W-1:0] prod;
  logic [COEF_W-1:0]        coef_q;

  fir_cell_mult #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W)
  ) u_mult (
    .data_i       (sample_i),
    .coef_i       (coef_i),
    .data_signed_i(data_signed_i),
    .coef_signed_i(coef_signed_i),
    .prod_o       (prod)
  );

  fir_cell_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .erase_i(erase_i),
    .prod_i (prod),
    .acc_o  (acc_o)
  );

  fir_cell_decim #(
    .WIDTH(DATA_W), .STAGES(DECIM_STAGES), .SEL_W(SEL_W)
  ) u_decim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (decim_sel_i),
    .data_i(sample_i),
    .data_o(sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        coef_q <= '0;
    else if (coef_en_i) coef_q <= coef_i;
  end

  assign coef_o = coef_q;
endmodule

// File: rtl/fir_mac_cell_chk.sv
module fir_mac_cell_chk #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned COEF_W       = 8,
  parameter int unsigned ACC_W        = 26,
  parameter int unsigned DECIM_STAGES = 3,
  parameter int unsigned SEL_W        = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] sample_i,
  input logic [COEF_W-1:0] coef_i,
  input logic              coef_en_i,
  input logic              data_signed_i,
  input logic              coef_signed_i,
  input logic [SEL_W-1:0]  decim_sel_i,
  input logic              erase_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic [DATA_W-1:0] sample_o,
  input logic [COEF_W-1:0] coef_o
);
  logic [2:0] age_q;  // edges since reset release, saturating

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  logic zero_op;
  assign zero_op = (sample_i == '0) || (coef_i == '0);

  p_coef_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_en_i |=> coef_o == $past(coef_i));

  p_coef_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_en_i |=> $stable(coef_o));

  p_zero_prod_keeps_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!erase_i && zero_op) |=> acc_o == $past(acc_o));

  p_erase_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && zero_op) |=> acc_o == '0);

  p_bypass_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd4 && decim_sel_i == SEL_W'(0)) |=> sample_o == $past(sample_i));

  if (DECIM_STAGES >= 1) begin : g_d1
    p_decim_by2_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 3'd4 && decim_sel_i == SEL_W'(1)) |=> sample_o == $past(sample_i, 2));
  end
  if (DECIM_STAGES >= 2) begin : g_d2
    p_decim_by3_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 3'd4 && decim_sel_i == SEL_W'(2)) |=> sample_o == $past(sample_i, 3));
  end
  if (DECIM_STAGES >= 3) begin : g_d3
    p_decim_by4_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 3'd4 && decim_sel_i == SEL_W'(3)) |=> sample_o == $past(sample_i, 4));
  end
endmodule

bind fir_mac_cell fir_mac_cell_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
  .DECIM_STAGES(DECIM_STAGES), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_fir_mac_cell.sv
module sim_fir_mac_cell;
  localparam time CLK_PERIOD = 10ns;
  localparam int  ACC_W      = 26;
  localparam int  WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sample_i = '0;
  logic [7:0]  coef_i = '0;
  logic        coef_en_i = 1'b0;
  logic        data_signed_i = 1'b0;
  logic        coef_signed_i = 1'b0;
  logic [1:0]  decim_sel_i = '0;
  logic        erase_i = 1'b0;
  logic [25:0] acc_o;
  logic [7:0]  sample_o;
  logic [7:0]  coef_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [25:0] acc_m  = '0;
  logic [7:0]  coef_m = '0;
  logic [7:0]  hist [3] = '{default: '0};
  logic [25:0] exp_acc;
  logic [7:0]  exp_samp;
  logic [7:0]  exp_coef;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  fir_mac_cell u0 (.*);

  function automatic int opval(logic [7:0] v, logic sgn);
    int r = int'(v);
    if (sgn && v >= 8'd128) r = r - 256;
    return r;
  endfunction

  function automatic logic [25:0] prod26(logic [7:0] d, logic ds, logic [7:0] c, logic cs);
    int p = opval(d, ds) * opval(c, cs);
    return p[25:0];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive one edge worth of inputs at a falling edge, check after the next rising edge
  task automatic cyc(logic [7:0] s, logic [7:0] c, logic ce, logic ds, logic cs,
                     logic [1:0] sel, logic er, string acc_req);
    string sreq;
    sample_i = s; coef_i = c; coef_en_i = ce;
    data_signed_i = ds; coef_signed_i = cs; decim_sel_i = sel; erase_i = er;
    exp_acc  = (er ? 26'd0 : acc_m) + prod26(s, ds, c, cs);
    exp_samp = (sel == 2'd0) ? s : hist[sel - 2'd1];
    exp_coef = ce ? c : coef_m;
    acc_m = exp_acc; coef_m = exp_coef;
    hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
    @(negedge clk_i);
    sreq = (sel == 2'd0) ? "R7" : "R8";
    chk(acc_req, "acc_o", 32'(acc_o), 32'(exp_acc));
    chk(sreq, "sample_o", 32'(sample_o), 32'(exp_samp));
    chk("R6", "coef_o", 32'(coef_o), 32'(exp_coef));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset with active inputs
    sample_i = 8'hA5; coef_i = 8'h3C; coef_en_i = 1'b1; decim_sel_i = 2'd0;
    repeat (3) @(negedge clk_i);
    chk("R1", "acc_o", 32'(acc_o), 0);
    chk("R1", "sample_o", 32'(sample_o), 0);
    chk("R1", "coef_o", 32'(coef_o), 0);
    sample_i = '0; coef_i = '0; coef_en_i = 1'b0;
    rst_ni = 1'b1;

    // R2/R3: mixed-mode single products after erase
    cyc(8'h80, 8'h02, 1, 1, 0, 0, 1, "R2");  // -128 * 2
    cyc(8'h80, 8'h02, 1, 0, 0, 0, 1, "R2");  // 128 * 2
    cyc(8'h80, 8'hFF, 1, 0, 1, 0, 1, "R3");  // 128 * -1
    cyc(8'h80, 8'hFF, 1, 0, 0, 0, 1, "R3");  // 128 * 255
    cyc(8'hFF, 8'hFF, 1, 1, 1, 0, 1, "R2");  // -1 * -1
    cyc(8'h80, 8'h80, 0, 1, 1, 0, 1, "R3");  // -128 * -128
    // R4: accumulate, then R5 restart
    cyc(8'h10, 8'h10, 0, 0, 0, 1, 0, "R4");
    cyc(8'hF0, 8'h01, 0, 1, 0, 2, 0, "R4");
    cyc(8'h00, 8'h55, 1, 0, 0, 3, 0, "R4");
    cyc(8'h07, 8'h03, 0, 0, 0, 3, 1, "R5");

    // R8 directed: sweep each selector with a ramp
    for (int sel = 0; sel < 4; sel++)
      for (int i = 0; i < 8; i++)
        cyc(8'(i * 17 + sel), 8'h01, 0, 0, 0, 2'(sel), 0, "R4");

    // R9: long run of maximum unsigned products wraps past 2^26
    cyc(8'hFF, 8'hFF, 1, 0, 0, 0, 1, "R5");
    for (int i = 0; i < 1100; i++)
      cyc(8'hFF, 8'hFF, 0, 0, 0, 0, 0, "R9");
    // R9: negative run wraps below zero
    cyc(8'h80, 8'h7F, 0, 1, 1, 0, 1, "R5");
    for (int i = 0; i < 20; i++)
      cyc(8'h80, 8'h7F, 0, 1, 1, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic er;
      er = ($urandom % 8) == 0;
      cyc(8'($urandom), 8'($urandom), ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
          2'($urandom), er, er ? "R5" : "R4");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule